// File: doc/BRIEF.md
# Interval Timer Counter Channel

This block is a single down-counting timer channel. A free-running tick enable sets the count rate. The host loads a 16-bit start value, and the channel restarts from that value. The count then steps down by one on each tick. After it reaches 1, the next tick returns it to the start value. A stored value of zero has no useful meaning, so a load of zero is kept as the full-scale value.

The channel has two behaviours:

- One-shot mode (mode 0): the first terminal count raises an interrupt and sets a sticky fired flag. The flag drives the output level.
- Periodic mode (mode 3, and every other non-zero mode): each terminal count raises an interrupt. The output level is a square wave, high during the upper half of the count.

A snapshot request copies the live count into a latch that the host can read. The register decode and byte sequencing sit in a neighbouring block, which drives the strobes of this channel.

Top module: `interval_timer_ch`

## Requirements
- R1: After reset, the start value and the live count are 0xFFFF, the mode is one-shot, and the fired flag is clear. While reset is held, `irq_pulse` and `out_level` are 0 and `snap_count` is 0.
- R2: A load of 0 is stored as the start value 0xFFFF.
- R3: A load makes the live count equal to the new start value and clears the fired flag. When a load and a tick arrive in the same cycle, the load wins and the count does not decrement.
- R4: The live count decrements only in cycles where `tick_en` is 1. A tick at count 1 returns the count to the start value. The count is therefore always the start value minus (ticks since load modulo the start value).
- R5: `irq_pulse` is 1 for exactly the one cycle after the clock edge at which a tick took the count from 1 back to the start value, if the mode allows an interrupt.
- R6: In one-shot mode, the first terminal count after a load gives an interrupt and sets the fired flag. Further terminal counts give no interrupt until the next load. `out_level` equals the fired flag in this mode.
- R7: In periodic mode, every terminal count gives an interrupt, so with start value N one pulse follows every N ticks. With N = 1, every tick gives a pulse.
- R8: In periodic mode, `out_level` is 1 while the live count is greater than floor(start value / 2), and 0 otherwise.
- R9: When `snap_req` is 1 at a clock edge, `snap_count` takes the live count as it stood before that edge's tick or load. Otherwise `snap_count` holds its value.
- R10: A mode write (`mode_wr` with `mode_val`) changes the mode from the next cycle but does not restart or alter the count. A terminal count in the same cycle as the write follows the old mode.
- R11: `mode_val` 0 selects one-shot mode. Every other value (1 to 7) selects periodic mode, including the ones that have no behaviour of their own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_en | input | 1 | Count-enable tick |
| load_en | input | 1 | Load strobe for a new start value |
| load_value | input | 16 | Start value to load (0 means 0xFFFF) |
| mode_wr | input | 1 | Mode write strobe |
| mode_val | input | 3 | Requested mode (0 one-shot, other values periodic) |
| snap_req | input | 1 | Copy the live count into the snapshot latch |
| irq_pulse | output | 1 | One-cycle interrupt pulse at terminal count |
| out_level | output | 1 | Output level: fired flag in one-shot, square wave in periodic |
| snap_count | output | 16 | Snapshot latch |

## Verification
The bench goes after the following corner cases, and what a faulty design would do in each:

- **Zero load.** A design that stored the zero literally would count from 0, show a wrapped snapshot, and never reach terminal count.
- **Load and tick in the same cycle.** A design that lets the tick win would snapshot one below the start value.
- **One-shot mode past its first terminal count.** Ticking on here catches designs that fire again, or that drop the fired level.
- **Periodic mode with an odd start value and with start value 1.** An off-by-one in the half comparison moves the `out_level` edge by a tick. A terminal-count detector that needs two ticks drops pulses.
- **Mode writes in the middle of a count.** A write that restarted the count would show up in the next snapshot.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  typedef enum logic {
    MODE_ONESHOT  = 1'b0,
    MODE_PERIODIC = 1'b1
  } tmr_mode_e;

  // Mode 0 keeps the one-shot behaviour; every other request runs periodic.
  function automatic tmr_mode_e map_mode(input logic [2:0] req);
    return (req == 3'd0) ? MODE_ONESHOT : MODE_PERIODIC;
  endfunction
endpackage

// File: rtl/tmr_reload.sv
`timescale 1ns/1ps
module tmr_reload
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_value,
  input  logic         mode_wr,
  input  logic [2:0]   mode_val,
  output logic [W-1:0] start_nxt,
  output logic [W-1:0] start_val,
  output tmr_mode_e    mode
);
  localparam logic [W-1:0] FULL = {W{1'b1}};

  logic [W-1:0] start_d;
  tmr_mode_e    mode_d;

  // An empty start value stands for the full count.
  assign start_nxt = (load_value == '0) ? FULL : load_value;

  always_comb begin
    start_d = start_val;
    mode_d  = mode;
    if (load_en) start_d = start_nxt;
    if (mode_wr) mode_d  = map_mode(mode_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_val <= FULL;
      mode      <= MODE_ONESHOT;
    end else begin
      start_val <= start_d;
      mode      <= mode_d;
    end
  end

  a_r2_zero_load_full: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && load_value == '0) |=> (start_val == FULL));

  a_r11_nonzero_mode_periodic: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_val != 3'd0) |=> (mode == MODE_PERIODIC));

  a_r11_zero_mode_oneshot: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_val == 3'd0) |=> (mode == MODE_ONESHOT));
endmodule

// File: rtl/tmr_down.sv
`timescale 1ns/1ps
module tmr_down #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         load_en,
  input  logic [W-1:0] start_nxt,
  input  logic [W-1:0] start_val,
  output logic [W-1:0] cnt,
  output logic         term
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] FULL = {W{1'b1}};

  logic [W-1:0] cnt_d;

  // Terminal count: a tick that takes the count from 1 back to the start value.
  assign term = tick_en && !load_en && (cnt == ONE);

  always_comb begin
    cnt_d = cnt;
    if (load_en)      cnt_d = start_nxt;
    else if (term)    cnt_d = start_val;
    else if (tick_en) cnt_d = cnt - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= FULL;
    else        cnt <= cnt_d;
  end

  a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !load_en) |=> $stable(cnt));

  a_r4_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) && (cnt <= start_val));

  a_r3_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (cnt == start_val));
endmodule

// File: rtl/tmr_outs.sv
`timescale 1ns/1ps
module tmr_outs
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic         term,
  input  tmr_mode_e    mode,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] start_val,
  input  logic         snap_req,
  output logic         irq,
  output logic         level,
  output logic [W-1:0] snap
);
  logic         fired;
  logic         fired_d;
  logic         irq_d;
  logic [W-1:0] snap_d;
  logic [W-1:0] half;

  assign half = start_val >> 1;

  always_comb begin
    irq_d   = term && ((mode == MODE_PERIODIC) || !fired);
    fired_d = fired;
    if (load_en)                          fired_d = 1'b0;
    else if (term && mode == MODE_ONESHOT) fired_d = 1'b1;
    snap_d  = snap_req ? cnt : snap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fired <= 1'b0;
      irq   <= 1'b0;
      snap  <= '0;
    end else begin
      fired <= fired_d;
      irq   <= irq_d;
      snap  <= snap_d;
    end
  end

  assign level = (mode == MODE_PERIODIC) ? (cnt > half) : fired;

  a_r6_fired_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fired && !load_en) |=> fired);

  a_r6_no_second_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ONESHOT && fired) |=> !irq);

  a_r5_irq_after_term: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(term));

  a_r9_snap_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_req |=> $stable(snap));
endmodule

// File: rtl/interval_timer_ch.sv
`timescale 1ns/1ps
module interval_timer_ch
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         load_en,
  input  logic [W-1:0] load_value,
  input  logic         mode_wr,
  input  logic [2:0]   mode_val,
  input  logic         snap_req,
  output logic         irq_pulse,
  output logic         out_level,
  output logic [W-1:0] snap_count
);
  logic [W-1:0] start_nxt;
  logic [W-1:0] start_val;
  logic [W-1:0] cnt;
  logic         term;
  tmr_mode_e    mode;

  tmr_reload #(.W(W)) u_reload (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (load_en),
    .load_value (load_value),
    .mode_wr    (mode_wr),
    .mode_val   (mode_val),
    .start_nxt  (start_nxt),
    .start_val  (start_val),
    .mode       (mode)
  );

  tmr_down #(.W(W)) u_down (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .load_en   (load_en),
    .start_nxt (start_nxt),
    .start_val (start_val),
    .cnt       (cnt),
    .term      (term)
  );

  tmr_outs #(.W(W)) u_outs (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .term      (term),
    .mode      (mode),
    .cnt       (cnt),
    .start_val (start_val),
    .snap_req  (snap_req),
    .irq       (irq_pulse),
    .level     (out_level),
    .snap      (snap_count)
  );

  a_r10_mode_write_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !load_en && !tick_en) |=> $stable(cnt));
endmodule

// File: tb/interval_timer_ch_test.sv
`timescale 1ns/1ps
module interval_timer_ch_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en, load_en, mode_wr, snap_req;
  logic [15:0] load_value;
  logic [2:0]  mode_val;
  logic        irq_pulse, out_level;
  logic [15:0] snap_count;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string phase = "R1";

  // Scoreboard queues, one entry per clock edge.
  logic        q_irq[$];
  logic        q_lvl[$];
  logic [15:0] q_snap[$];
  string       q_req[$];

  // Reference state built from the requirements.
  logic [15:0] m_start, m_cnt, m_snap;
  logic        m_per, m_fired;

  always #4 clk = ~clk;

  interval_timer_ch uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load_en(load_en),
    .load_value(load_value), .mode_wr(mode_wr), .mode_val(mode_val),
    .snap_req(snap_req), .irq_pulse(irq_pulse), .out_level(out_level),
    .snap_count(snap_count)
  );

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic ld, input logic [15:0] lv,
                      input logic mw, input logic [2:0] mv, input logic sn);
    logic term;
    logic nirq;
    logic lvl;
    @(negedge clk);
    tick_en = t; load_en = ld; load_value = lv;
    mode_wr = mw; mode_val = mv; snap_req = sn;
    term = t && !ld && (m_cnt == 16'd1);
    nirq = term && (m_per || !m_fired);
    if (sn) m_snap = m_cnt;
    if (ld) begin
      m_start = (lv == 16'd0) ? 16'hFFFF : lv;
      m_cnt   = m_start;
      m_fired = 1'b0;
    end else if (t) begin
      if (m_cnt == 16'd1) begin
        m_cnt = m_start;
        if (!m_per) m_fired = 1'b1;
      end else begin
        m_cnt = m_cnt - 16'd1;
      end
    end
    if (mw) m_per = (mv != 3'd0);
    lvl = m_per ? (m_cnt > (m_start >> 1)) : m_fired;
    q_irq.push_back(nirq);
    q_lvl.push_back(lvl);
    q_snap.push_back(m_snap);
    q_req.push_back(phase);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 16'd0, 1'b0, 3'd0, 1'b0);
  endtask
  task automatic ticks_snap(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 16'd0, 1'b0, 3'd0, 1'b1);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 16'd0, 1'b0, 3'd0, 1'b0);
  endtask
  task automatic load(input logic [15:0] v);
    step(1'b0, 1'b1, v, 1'b0, 3'd0, 1'b0);
  endtask
  task automatic setmode(input logic [2:0] m);
    step(1'b0, 1'b0, 16'd0, 1'b1, m, 1'b0);
  endtask
  task automatic snap();
    step(1'b0, 1'b0, 16'd0, 1'b0, 3'd0, 1'b1);
  endtask

  // Monitor: compare each edge's results after the outputs settle.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_snap.size() > 0) begin
        string r;
        r = q_req.pop_front();
        check(r, "irq_pulse", {15'd0, irq_pulse}, {15'd0, q_irq.pop_front()});
        check(r, "out_level", {15'd0, out_level}, {15'd0, q_lvl.pop_front()});
        check(r, "snap_count", snap_count, q_snap.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    tick_en = 1'b0; load_en = 1'b0; load_value = 16'd0;
    mode_wr = 1'b0; mode_val = 3'd0; snap_req = 1'b0;
    m_start = 16'hFFFF; m_cnt = 16'hFFFF; m_snap = 16'd0;
    m_per = 1'b0; m_fired = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs while reset is held
    check("R1", "irq_pulse", {15'd0, irq_pulse}, 16'd0);
    check("R1", "out_level", {15'd0, out_level}, 16'd0);
    check("R1", "snap_count", snap_count, 16'd0);
    rst_n = 1'b1;

    phase = "R1";  snap(); ticks(2); snap();
    phase = "R2";  load(16'd0); snap(); ticks(3); snap();
    phase = "R4";  load(16'd5); idle(3); snap(); ticks_snap(4); idle(2); snap();
    phase = "R5";  ticks_snap(2);
    phase = "R6";  ticks_snap(12); idle(2);
    phase = "R3";  load(16'd4); snap();
                   step(1'b1, 1'b1, 16'd7, 1'b0, 3'd0, 1'b0); snap(); ticks_snap(3);
    phase = "R7";  setmode(3'd3); load(16'd6); ticks_snap(20);
    phase = "R8";  load(16'd5); ticks_snap(12); load(16'd2); ticks_snap(5);
    phase = "R11"; setmode(3'd2); load(16'd3); ticks_snap(8);
                   setmode(3'd7); ticks_snap(4); setmode(3'd1); load(16'd1); ticks_snap(5);
    phase = "R10"; load(16'd9); ticks(3); setmode(3'd0); snap(); ticks_snap(8);
                   load(16'd3); ticks(2);
                   step(1'b1, 1'b0, 16'd0, 1'b1, 3'd3, 1'b1); ticks_snap(6);
    phase = "R9";  idle(1); snap(); idle(3);

    while (q_snap.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule